// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between a product-term array and a row of macrocell OR gates. The product terms come in as a flat vector and are grouped into clusters of a fixed size, one cluster per macrocell. Each cluster has a static two-bit route setting. The setting sends the whole cluster to one macrocell in a window of three neighbours: the macrocell one index lower, the macrocell with the same index, or the macrocell one index higher. The setting can also leave the cluster idle.

Each macrocell produces one sum-of-products bit. That bit is the OR of every term in every cluster steered to it. With the default sizes, an interior macrocell can therefore gather up to twelve terms. The two end macrocells can gather up to eight.

A route that points past either end of the row is a configuration error. Such a route raises a per-cluster error flag, and the cluster then feeds nothing. By default the outputs are purely combinational. A parameter inserts one register stage on both the sum-of-products outputs and the error outputs. That stage has its own reset release.

Top module: `pterm_steer`

## Requirements
- R1: Route code 2'b01 on cluster c (bits [2c+1:2c] of the route vector) sends cluster c, which is term bits [4c+3:4c], to macrocell c-1.
- R2: Route code 2'b10 on cluster c sends that cluster to macrocell c.
- R3: Route code 2'b11 on cluster c sends that cluster to macrocell c+1.
- R4: Route code 2'b00 leaves cluster c idle, so its terms reach no macrocell.
- R5: Each macrocell output is the OR of all terms of all clusters routed to it. For an interior macrocell this means up to three clusters, or twelve terms.
- R6: A macrocell that no cluster is routed to outputs 0, whatever the term inputs are.
- R7: Code 2'b01 on cluster 0, or code 2'b11 on the last cluster, sets the error bit for that cluster (cfg_err_o[c]), and that cluster then contributes to no macrocell.
- R8: Every other combination of cluster and code leaves that cluster's error bit at 0.
- R9: With REG_OUT=1, once reset has been released both outputs equal the combinational result of the inputs present at the previous rising clock edge.
- R10: With REG_OUT=1, both outputs read 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pterm_i | input | NUM_MC*TERMS_PER_CL | Product-term bits, cluster c in bits [TERMS_PER_CL*c +: TERMS_PER_CL] |
| route_i | input | 2*NUM_MC | Static route code per cluster, cluster c in bits [2c +: 2] |
| sop_o | output | NUM_MC | Sum-of-products bit per macrocell |
| cfg_err_o | output | NUM_MC | Out-of-range route flag per cluster |

## Verification
The first sweep steps each cluster alone through all four codes and all sixteen term patterns. This separates the three directions from the idle code, and it shows that only an all-zero cluster leaves its destination low. It also shows that out-of-range codes at the two ends raise the flag and move nothing.

A second pattern routes three clusters into one interior macrocell and raises each of the twelve terms on its own. This shows that every term of the full fan-in reaches the OR.

Long runs of pseudo-random route vectors with sparse terms then exercise mixed sharing and idle macrocells against an arithmetic model. The registered variant is checked against the same model one edge later, and it is also checked to hold zero during reset.

// File: rtl/pterm_steer_pkg.sv
package pterm_steer_pkg;

  localparam int unsigned ROUTE_W = 2;

  typedef enum logic [ROUTE_W-1:0] {
    RT_OFF  = 2'b00,
    RT_DOWN = 2'b01,
    RT_SAME = 2'b10,
    RT_UP   = 2'b11
  } route_e;

  typedef struct packed {
    logic up;
    logic same;
    logic down;
  } dir_t;

endpackage

// File: rtl/pterm_steer_dec.sv
module pterm_steer_dec
  import pterm_steer_pkg::*;
#(
  parameter int unsigned TERMS   = 4,
  parameter bit          EDGE_LO = 1'b0,
  parameter bit          EDGE_HI = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROUTE_W-1:0] code_i,
  input  logic [TERMS-1:0]   terms_i,
  output dir_t               sel_o,
  output logic               hit_o,
  output logic               err_o
);

  always_comb begin
    sel_o = '0;
    err_o = 1'b0;
    case (code_i)
      RT_DOWN: begin
        if (EDGE_LO) err_o = 1'b1;
        else         sel_o.down = 1'b1;
      end
      RT_SAME: sel_o.same = 1'b1;
      RT_UP: begin
        if (EDGE_HI) err_o = 1'b1;
        else         sel_o.up = 1'b1;
      end
      default: ;
    endcase
  end

  assign hit_o = |terms_i;

  AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o)); // R2

  AST_IDLE_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == RT_OFF) |-> (sel_o == '0)); // R4

  AST_ERR_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (sel_o == '0)); // R7

endmodule

// File: rtl/pterm_steer_stage.sv
module pterm_steer_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [1:0]   rel_sync_q;
  logic         load_en;
  logic         loaded_q;
  logic [W-1:0] data_q;
  logic [W-1:0] data_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_sync_q <= 2'b00;
    else        rel_sync_q <= {rel_sync_q[0], 1'b1};
  end

  assign load_en = rel_sync_q[1];

  always_comb begin
    data_nxt = data_q;
    if (load_en) data_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      data_q   <= data_nxt;
      loaded_q <= load_en;
    end
  end

  assign q_o = data_q;

  AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> (q_o == $past(d_i))); // R9

  AST_HOLD_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |-> (q_o == '0)); // R10

endmodule

// File: rtl/pterm_steer.sv
module pterm_steer
  import pterm_steer_pkg::*;
#(
  parameter int unsigned NUM_MC       = 8,
  parameter int unsigned TERMS_PER_CL = 4,
  parameter bit          REG_OUT      = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_MC*TERMS_PER_CL-1:0]   pterm_i,
  input  logic [NUM_MC*ROUTE_W-1:0]        route_i,
  output logic [NUM_MC-1:0]                sop_o,
  output logic [NUM_MC-1:0]                cfg_err_o
);

  localparam int unsigned OUT_W = 2 * NUM_MC;

  dir_t              sel [NUM_MC];
  logic [NUM_MC-1:0] hit;
  logic [NUM_MC-1:0] err_c;
  logic [NUM_MC-1:0] sop_c;

  for (genvar cl = 0; cl < NUM_MC; cl++) begin : g_cluster
    pterm_steer_dec #(
      .TERMS   (TERMS_PER_CL),
      .EDGE_LO (cl == 0),
      .EDGE_HI (cl == NUM_MC - 1)
    ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .code_i  (route_i[cl*ROUTE_W +: ROUTE_W]),
      .terms_i (pterm_i[cl*TERMS_PER_CL +: TERMS_PER_CL]),
      .sel_o   (sel[cl]),
      .hit_o   (hit[cl]),
      .err_o   (err_c[cl])
    );
  end

  for (genvar mc = 0; mc < NUM_MC; mc++) begin : g_macro
    logic lo_sel, lo_hit;
    logic hi_sel, hi_hit;
    logic fed;

    if (mc > 0) begin : g_lo
      assign lo_sel = sel[mc-1].up;
      assign lo_hit = hit[mc-1];
    end else begin : g_lo_none
      assign lo_sel = 1'b0;
      assign lo_hit = 1'b0;
    end

    if (mc < NUM_MC - 1) begin : g_hi
      assign hi_sel = sel[mc+1].down;
      assign hi_hit = hit[mc+1];
    end else begin : g_hi_none
      assign hi_sel = 1'b0;
      assign hi_hit = 1'b0;
    end

    assign sop_c[mc] = (lo_sel & lo_hit) | (sel[mc].same & hit[mc]) | (hi_sel & hi_hit);
    assign fed       = lo_sel | sel[mc].same | hi_sel;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !fed |-> !sop_c[mc]); // R6

    AST_SOP_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      sop_c[mc] |-> fed); // R5
  end

  if (REG_OUT) begin : g_reg
    logic [OUT_W-1:0] stage_q;
    pterm_steer_stage #(.W(OUT_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({err_c, sop_c}),
      .q_o   (stage_q)
    );
    assign sop_o     = stage_q[NUM_MC-1:0];
    assign cfg_err_o = stage_q[OUT_W-1:NUM_MC];
  end else begin : g_comb
    assign sop_o     = sop_c;
    assign cfg_err_o = err_c;
  end

  AST_INTERIOR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_c & ~{1'b1, {(NUM_MC-2){1'b0}}, 1'b1}) == '0); // R8

endmodule

// File: tb/sim_pterm_steer.sv
module sim_pterm_steer;

  localparam int NMC = 8;
  localparam int TPC = 4;
  localparam int PTW = NMC * TPC;
  localparam int RTW = NMC * 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [PTW-1:0] pterm = '0;
  logic [RTW-1:0] route = '0;
  logic [NMC-1:0] sop0, err0, sop1, err1;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pterm_steer #(.NUM_MC(NMC), .TERMS_PER_CL(TPC), .REG_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pterm_i(pterm), .route_i(route),
    .sop_o(sop0), .cfg_err_o(err0));

  pterm_steer #(.NUM_MC(NMC), .TERMS_PER_CL(TPC), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pterm_i(pterm), .route_i(route),
    .sop_o(sop1), .cfg_err_o(err1));

  function automatic logic [NMC-1:0] model_sop(input logic [RTW-1:0] r, input logic [PTW-1:0] t);
    logic [NMC-1:0] s = '0;
    for (int c = 0; c < NMC; c++) begin
      int code = int'(r[2*c +: 2]);
      int dst  = c + code - 2;
      if (code != 0 && dst >= 0 && dst < NMC)
        s[dst] = s[dst] | (|t[TPC*c +: TPC]);
    end
    return s;
  endfunction

  function automatic logic [NMC-1:0] model_err(input logic [RTW-1:0] r);
    logic [NMC-1:0] e = '0;
    for (int c = 0; c < NMC; c++) begin
      int code = int'(r[2*c +: 2]);
      int dst  = c + code - 2;
      if (code != 0 && (dst < 0 || dst >= NMC)) e[c] = 1'b1;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [NMC-1:0] act, input logic [NMC-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b route=%h terms=%h", tag, act, exp, route, pterm);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    logic [PTW-1:0] ta;

    // R10: registered outputs stay zero while reset is held, even with live input
    route = {NMC{2'b10}};
    pterm = '1;
    repeat (3) @(negedge clk);
    chk("R10 sop in reset", sop1, '0);
    chk("R10 err in reset", err1, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Sweep 1: one cluster at a time, all codes, all term patterns
    for (int c = 0; c < NMC; c++) begin
      for (int code = 0; code < 4; code++) begin
        for (int p = 0; p < 16; p++) begin
          string tag;
          logic  edge_bad;
          route = RTW'(code) << (2 * c);
          pterm = PTW'(p) << (TPC * c);
          edge_bad = (c == 0 && code == 1) || (c == NMC - 1 && code == 3);
          case (code)
            0: tag = "R4 idle";
            1: tag = edge_bad ? "R7 low edge" : "R1 down";
            2: tag = "R2 same";
            default: tag = edge_bad ? "R7 high edge" : "R3 up";
          endcase
          #1;
          chk(tag, sop0, model_sop(route, pterm));
          chk(edge_bad ? "R7 flag" : "R8 no flag", err0, model_err(route));
          @(negedge clk);
        end
      end
    end

    // Sweep 2: full twelve-term fan-in into each interior macrocell
    for (int m = 1; m < NMC - 1; m++) begin
      for (int b = 0; b < 3 * TPC; b++) begin
        route = '0;
        route[2*(m-1) +: 2] = 2'b11;
        route[2*m     +: 2] = 2'b10;
        route[2*(m+1) +: 2] = 2'b01;
        pterm = PTW'(1) << (TPC * (m - 1) + b);
        #1;
        chk("R5 fan-in", sop0, NMC'(1) << m);
        @(negedge clk);
      end
    end

    // R6: nothing routed, all terms high
    route = '0;
    pterm = '1;
    #1;
    chk("R6 all idle", sop0, '0);
    @(negedge clk);

    // Sweep 3: pseudo-random routes with sparse terms, both variants
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      route = lf[RTW-1:0];
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ta = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pterm = ta & lf & {lf[15:0], lf[31:16]};
      #1;
      chk("R5 mixed", sop0, model_sop(route, pterm));
      chk("R8 mixed flags", err0, model_err(route));
      @(posedge clk);
      #2;
      chk("R9 reg sop", sop1, model_sop(route, pterm));
      chk("R9 reg err", err1, model_err(route));
      @(negedge clk);
    end

    finish_run();
  end

endmodule